// File: doc/BRIEF.md
# Set-Associative Translation Cache

This block keeps a small number of recent page-table entries next to the address path. A lookup presents a full virtual address. The virtual page number is split into a set index and a tag, and the page offset plays no part in that split. Both ways of the chosen set compare their tags in parallel. On a hit, the block returns the physical address, formed from the cached physical page number and the untouched offset, together with the permission bits. On a miss it raises a miss flag so that an external page walker can fetch the entry and write it back through the fill port.

The organisation is two ways by 2^SET_W sets, with 16 sets by default, 4 KiB pages and 32-bit addresses. A lookup is answered combinationally in the cycle it is presented. Each set keeps one recency bit that picks the replacement way. A single flush input drops every cached translation at once.

Top module: `tlb_set_assoc`

## Requirements
- R1: The set index is vaddr[PAGE_W+SET_W-1:PAGE_W] (bits 15:12 by default), the tag is vaddr[VA_W-1:PAGE_W+SET_W] (bits 31:16), and vaddr[PAGE_W-1:0] never takes part in the match. For the fill port, fill_vpn[SET_W-1:0] is the set and the upper bits of fill_vpn are the tag.
- R2: When lk_valid is 1 and a valid way in the indexed set holds a matching tag, lk_hit is 1 in the same cycle, lk_paddr is {stored ppn, vaddr[PAGE_W-1:0]} and lk_perm is the stored permission field.
- R3: When lk_valid is 1 and no valid way matches, lk_miss is 1 and lk_hit is 0. When lk_valid is 0, both outputs are 0. lk_hit and lk_miss are never 1 together.
- R4: A fill with fill_en=1 is written on the rising edge, so it is visible to lookups from the following cycle and not in the cycle it is presented.
- R5: When a fill creates a new entry in a set that has an invalid way, it uses an invalid way. Way 0 is taken before way 1.
- R6: When both ways of a set are valid, a new fill replaces the way that was not most recently hit or filled in that set. If a hit and a fill reach the same set in one cycle, the fill decides the recency.
- R7: A fill whose set and tag match a valid entry overwrites that entry, so the other way of the set is kept and no duplicate tag can exist.
- R8: A flush clears every valid bit on the next edge, and a lookup in the following cycle misses. A fill presented in the same cycle as a flush is discarded.
- R9: While rst_n is 0, lk_hit and lk_miss are both 0. After reset, every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation absent; walk required |
| lk_paddr | output | PPN_W+PAGE_W | Physical address (valid with lk_hit) |
| lk_perm | output | PERM_W | Permission bits (valid with lk_hit) |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | VA_W-PAGE_W | Virtual page number of the fill |
| fill_ppn | input | PPN_W | Physical page number of the fill |
| fill_perm | input | PERM_W | Permission bits of the fill |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench varies one address field at a time. It looks up the same tag in a different set, a different tag in the same set, and different offsets within a filled page, which separates an incorrect index or tag split from a working one. In one set it runs a sequence of fills and hits that forces replacement: an invalid way is taken first, then the older way is evicted, and then a same-tag refill arrives while the recency bit points at the other way. That last case tells an in-place overwrite apart from a duplicate entry. Lookups at the extreme sets and tags, with all-ones and all-zeros fields, flush and fill presented together, and a lookup in the same cycle as its own fill check the boundaries.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   // default geometry of the translation cache
   localparam int unsigned DEF_VA_W   = 32;
   localparam int unsigned DEF_PAGE_W = 12;
   localparam int unsigned DEF_SET_W  = 4;
   localparam int unsigned DEF_PPN_W  = 20;
   localparam int unsigned DEF_PERM_W = 4;
   // replacement needs exactly one recency bit per set
   localparam int unsigned NUM_WAYS   = 2;

   typedef logic way_idx_t;
endpackage

// File: rtl/tlb_way.sv
// One way of the cache: valid bits, tags and entries for every set,
// one lookup compare port and one fill-probe compare port.
module tlb_way #(
   parameter int unsigned SET_W = 4,
   parameter int unsigned TAG_W = 16,
   parameter int unsigned PTE_W = 24,
   localparam int unsigned SETS = 1 << SET_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_all,
   input  logic             wr_en,
   input  logic [SET_W-1:0] wr_set,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PTE_W-1:0] wr_pte,
   input  logic [SET_W-1:0] lk_set,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             lk_match,
   output logic [PTE_W-1:0] lk_pte,
   input  logic [SET_W-1:0] pr_set,
   input  logic [TAG_W-1:0] pr_tag,
   output logic             pr_match,
   output logic             pr_valid
);
   logic [SETS-1:0]  vld_q;
   logic [TAG_W-1:0] tag_q [SETS];
   logic [PTE_W-1:0] pte_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (clr_all) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[wr_set] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !clr_all) begin
         tag_q[wr_set] <= wr_tag;
         pte_q[wr_set] <= wr_pte;
      end
   end

   always_comb begin
      lk_match = vld_q[lk_set] && (tag_q[lk_set] == lk_tag);
      lk_pte   = pte_q[lk_set];
      pr_valid = vld_q[pr_set];
      pr_match = vld_q[pr_set] && (tag_q[pr_set] == pr_tag);
   end
endmodule

// File: rtl/tlb_lru.sv
// One recency bit per set; the stored value names the way to replace next.
module tlb_lru #(
   parameter int unsigned SET_W = 4,
   localparam int unsigned SETS = 1 << SET_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_en,
   input  logic [SET_W-1:0] hit_set,
   input  logic             hit_way,
   input  logic             fill_en,
   input  logic [SET_W-1:0] fill_set,
   input  logic             fill_way,
   input  logic [SET_W-1:0] q_set,
   output logic             victim
);
   logic [SETS-1:0] old_q;

   for (genvar s = 0; s < SETS; s++) begin : g_set
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            old_q[s] <= 1'b0;
         end else if (fill_en && (fill_set == SET_W'(s))) begin
            // R6: a fill outranks a hit in the same set
            old_q[s] <= ~fill_way;
         end else if (hit_en && (hit_set == SET_W'(s))) begin
            old_q[s] <= ~hit_way;
         end
      end
   end

   assign victim = old_q[q_set];
endmodule

// File: rtl/tlb_victim.sv
// Picks the way a fill writes: matching entry, then an invalid way, then LRU.
module tlb_victim (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] pr_match,
   input  logic [1:0] pr_valid,
   input  logic       lru_way,
   output logic       fill_way
);
   always_comb begin
      if (pr_match[0])       fill_way = 1'b0;   // R7
      else if (pr_match[1])  fill_way = 1'b1;   // R7
      else if (!pr_valid[0]) fill_way = 1'b0;   // R5
      else if (!pr_valid[1]) fill_way = 1'b1;   // R5
      else                   fill_way = lru_way; // R6
   end

   // R7
   dup_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pr_match[0] && pr_match[1]));
endmodule

// File: rtl/tlb_set_assoc.sv
module tlb_set_assoc
   import tlb_pkg::*;
#(
   parameter int unsigned VA_W   = DEF_VA_W,
   parameter int unsigned PAGE_W = DEF_PAGE_W,
   parameter int unsigned SET_W  = DEF_SET_W,
   parameter int unsigned PPN_W  = DEF_PPN_W,
   parameter int unsigned PERM_W = DEF_PERM_W,
   localparam int unsigned VPN_W = VA_W - PAGE_W,
   localparam int unsigned TAG_W = VPN_W - SET_W,
   localparam int unsigned PTE_W = PPN_W + PERM_W,
   localparam int unsigned PA_W  = PPN_W + PAGE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VA_W-1:0]   lk_vaddr,
   output logic              lk_hit,
   output logic              lk_miss,
   output logic [PA_W-1:0]   lk_paddr,
   output logic [PERM_W-1:0] lk_perm,
   input  logic              fill_en,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic [PERM_W-1:0] fill_perm,
   input  logic              flush
);
   initial begin
      cfg_split_chk: assert (PAGE_W + SET_W < VA_W)
         else $fatal(1, "set index and offset leave no tag bits");
      cfg_ways_chk: assert (NUM_WAYS == 2)
         else $fatal(1, "single recency bit needs two ways");
   end

   // R1: index from the low VPN bits, tag from the rest, offset unused
   logic [SET_W-1:0] lk_set, fl_set;
   logic [TAG_W-1:0] lk_tag, fl_tag;
   assign lk_set = lk_vaddr[PAGE_W +: SET_W];
   assign lk_tag = lk_vaddr[VA_W-1 : PAGE_W+SET_W];
   assign fl_set = fill_vpn[SET_W-1:0];
   assign fl_tag = fill_vpn[VPN_W-1:SET_W];

   logic [NUM_WAYS-1:0] way_match, pr_match, pr_valid, way_wr;
   logic [PTE_W-1:0]    way_pte [NUM_WAYS];
   logic                fill_go, fill_way, lru_way, hit_any, hit_way;

   // R8: flush discards a fill in the same cycle
   assign fill_go = fill_en && !flush;

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      assign way_wr[w] = fill_go && (fill_way == way_idx_t'(w));
      tlb_way #(.SET_W(SET_W), .TAG_W(TAG_W), .PTE_W(PTE_W)) i_way (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr_all (flush),
         .wr_en   (way_wr[w]),
         .wr_set  (fl_set),
         .wr_tag  (fl_tag),
         .wr_pte  ({fill_ppn, fill_perm}),
         .lk_set  (lk_set),
         .lk_tag  (lk_tag),
         .lk_match(way_match[w]),
         .lk_pte  (way_pte[w]),
         .pr_set  (fl_set),
         .pr_tag  (fl_tag),
         .pr_match(pr_match[w]),
         .pr_valid(pr_valid[w])
      );
   end

   tlb_victim i_victim (
      .clk     (clk),
      .rst_n   (rst_n),
      .pr_match(pr_match),
      .pr_valid(pr_valid),
      .lru_way (lru_way),
      .fill_way(fill_way)
   );

   tlb_lru #(.SET_W(SET_W)) i_lru (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_en  (lk_hit),
      .hit_set (lk_set),
      .hit_way (hit_way),
      .fill_en (fill_go),
      .fill_set(fl_set),
      .fill_way(fill_way),
      .q_set   (fl_set),
      .victim  (lru_way)
   );

   // R2/R3/R9: combinational answer, silent in reset
   logic [PTE_W-1:0] sel_pte;
   assign hit_any = |way_match;
   assign hit_way = way_match[1];
   assign sel_pte = hit_way ? way_pte[1] : way_pte[0];
   assign lk_hit  = rst_n && lk_valid && hit_any;
   assign lk_miss = rst_n && lk_valid && !hit_any;
   assign lk_paddr = {sel_pte[PTE_W-1:PERM_W], lk_vaddr[PAGE_W-1:0]};
   assign lk_perm  = sel_pte[PERM_W-1:0];

   // R3
   outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_hit && lk_miss));
   // R3
   outcome_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> (lk_hit || lk_miss));
   // R8
   flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !lk_hit);
   // R9
   rst_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> !(lk_hit || lk_miss));
   // R7
   no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(way_match[0] && way_match[1]));
endmodule

// File: tb/test_tlb_set_assoc.sv
`timescale 1ns/1ps
module test_tlb_set_assoc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_vaddr = '0;
   logic        lk_hit, lk_miss;
   logic [31:0] lk_paddr;
   logic [3:0]  lk_perm;
   logic        fill_en = 1'b0;
   logic [19:0] fill_vpn = '0;
   logic [19:0] fill_ppn = '0;
   logic [3:0]  fill_perm = '0;
   logic        flush = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;   // 250 MHz

   tlb_set_assoc i_tlb_set_assoc (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
      .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr), .lk_perm(lk_perm),
      .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
      .fill_perm(fill_perm), .flush(flush)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // drive a lookup after a falling edge, sample 1 ns later, hold over the rising edge
   task automatic look(input string req, input logic [31:0] va, input logic exp_hit,
                       input logic [19:0] ppn, input logic [3:0] perm);
      @(negedge clk);
      lk_valid = 1'b1;
      lk_vaddr = va;
      #1;
      check({req, " hit"}, 64'(lk_hit), 64'(exp_hit));
      check({req, " miss"}, 64'(lk_miss), 64'(!exp_hit));
      if (exp_hit) begin
         check({req, " paddr"}, 64'(lk_paddr), 64'({ppn, va[11:0]}));
         check({req, " perm"}, 64'(lk_perm), 64'(perm));
      end
      @(posedge clk);
      #1 lk_valid = 1'b0;
   endtask

   task automatic fill(input logic [31:0] va, input logic [19:0] ppn, input logic [3:0] perm);
      @(negedge clk);
      fill_en = 1'b1;
      fill_vpn = va[31:12];
      fill_ppn = ppn;
      fill_perm = perm;
      @(posedge clk);
      #1 fill_en = 1'b0;
   endtask

   // {is_lookup, vaddr, ppn, perm, expect_hit}
   localparam int NVEC = 18;
   localparam logic [57:0] VEC [NVEC] = '{
      {1'b0, 32'h1234_5000, 20'hAAAAA, 4'h3, 1'b0}, // fill, set 5 way 0
      {1'b1, 32'h1234_5ABC, 20'hAAAAA, 4'h3, 1'b1}, // R2 hit
      {1'b1, 32'h1235_5ABC, 20'h00000, 4'h0, 1'b0}, // R3 other tag
      {1'b1, 32'h1234_6ABC, 20'h00000, 4'h0, 1'b0}, // R1 other set
      {1'b0, 32'h5678_5000, 20'h11111, 4'h5, 1'b0}, // R5 invalid way 1
      {1'b1, 32'h5678_5FFF, 20'h11111, 4'h5, 1'b1}, // R5
      {1'b1, 32'h1234_5000, 20'hAAAAA, 4'h3, 1'b1}, // R6 touch way 0
      {1'b0, 32'h9999_5000, 20'h22222, 4'h6, 1'b0}, // R6 evict 5678
      {1'b1, 32'h5678_5001, 20'h00000, 4'h0, 1'b0}, // R6 evicted
      {1'b1, 32'h1234_5001, 20'hAAAAA, 4'h3, 1'b1}, // R6 kept
      {1'b1, 32'h9999_5002, 20'h22222, 4'h6, 1'b1}, // R6 recency to way 1
      {1'b0, 32'h9999_5000, 20'h33333, 4'h7, 1'b0}, // R7 same tag refill
      {1'b1, 32'h1234_5003, 20'hAAAAA, 4'h3, 1'b1}, // R7 other way kept
      {1'b1, 32'h9999_5004, 20'h33333, 4'h7, 1'b1}, // R7 new data
      {1'b0, 32'hFFFF_F000, 20'hFFFFF, 4'hF, 1'b0}, // R1 top set and tag
      {1'b1, 32'hFFFF_FFFF, 20'hFFFFF, 4'hF, 1'b1}, // R1
      {1'b0, 32'h0000_0000, 20'h00001, 4'h1, 1'b0}, // R1 bottom set and tag
      {1'b1, 32'h0000_0FFF, 20'h00001, 4'h1, 1'b1}  // R1
   };

   initial begin
      // R9: quiet in reset
      lk_valid = 1'b1;
      lk_vaddr = 32'h1234_5000;
      repeat (3) @(negedge clk);
      #1;
      check("R9 hit in reset", 64'(lk_hit), 64'(0));
      check("R9 miss in reset", 64'(lk_miss), 64'(0));
      lk_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      look("R9 empty after reset", 32'h1234_5000, 1'b0, '0, '0);

      // R3: idle lookup port
      @(negedge clk);
      #1;
      check("R3 idle hit", 64'(lk_hit), 64'(0));
      check("R3 idle miss", 64'(lk_miss), 64'(0));

      for (int i = 0; i < NVEC; i++) begin
         if (VEC[i][57])
            look($sformatf("R1-3/5-7 vector %0d", i), VEC[i][56:25], VEC[i][0],
                 VEC[i][24:5], VEC[i][4:1]);
         else
            fill(VEC[i][56:25], VEC[i][24:5], VEC[i][4:1]);
      end

      // R4: fill not visible in its own cycle, visible in the next
      @(negedge clk);
      fill_en = 1'b1; fill_vpn = 20'h77777; fill_ppn = 20'h44444; fill_perm = 4'h9;
      lk_valid = 1'b1; lk_vaddr = 32'h7777_7123;
      #1;
      check("R4 same cycle", 64'(lk_hit), 64'(0));
      @(posedge clk);
      #1 fill_en = 1'b0;
      @(negedge clk);
      #1;
      check("R4 next cycle", 64'(lk_hit), 64'(1));
      check("R4 paddr", 64'(lk_paddr), 64'(32'h4444_4123));
      @(posedge clk);
      #1 lk_valid = 1'b0;

      // R8: flush then lookup misses
      @(negedge clk);
      flush = 1'b1;
      @(posedge clk);
      #1 flush = 1'b0;
      look("R8 after flush", 32'h1234_5000, 1'b0, '0, '0);
      look("R8 after flush top", 32'hFFFF_F000, 1'b0, '0, '0);

      // R8: fill with flush is dropped
      @(negedge clk);
      flush = 1'b1; fill_en = 1'b1; fill_vpn = 20'h44444; fill_ppn = 20'h55555;
      @(posedge clk);
      #1 begin flush = 1'b0; fill_en = 1'b0; end
      look("R8 fill dropped", 32'h4444_4000, 1'b0, '0, '0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule